// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block is the serial heart of an SPI master. Software-side logic writes a 32-bit control word that sets the clock polarity, the clock phase, the bit order, a receive-discard option and the chip-select handling. Writing the same word with its start bit set launches one burst. The engine moves 8-bit words. It pulls transmit bytes from an external transmit byte queue and hands received bytes to an external receive byte queue. It generates the serial clock from an externally supplied tick: each tick is one half period of the serial clock.

A burst has two lengths. The total count is the number of bytes clocked on the bus. The transmit count is how many of those bytes come from the transmit queue. Once the transmit count is used up, the engine shifts out zero bytes for the rest of the burst and still captures what comes back. When the burst ends, the engine clears the start bit and sets a completion flag. That flag is cleared by a write-one pulse and reaches the interrupt line only when the interrupt is enabled.

Top module: `spi_burst_engine`

## Requirements
- R1: The control word places clock phase at bit 0, clock polarity at bit 1 and LSB-first order at bit 12. It reads back exactly as written, and the serial clock rests at the polarity level while idle.
- R2: Every byte is exactly 16 serial clock edges. With phase 0, data is sampled on leading edges and changes on trailing edges. With phase 1, data changes on leading edges and is sampled on trailing edges.
- R3: With bit 12 clear, bit 7 goes first in both directions. With bit 12 set, bit 0 goes first in both directions.
- R4: The first min(transmit count, total count) bytes are each popped once from the transmit queue and shifted out. The later bytes shift out as zero and cause no pop. Both counts are 24 bits wide and are captured at start.
- R5: Each of the total-count received bytes is pushed to the receive queue in order. When bit 8 is set, nothing is pushed.
- R6: The chip-select index sits at bits 5:4. Outside manual mode, line cs_n[index] is driven low from start to completion. All other lines, and all lines while idle, stay high.
- R7: With manual mode (bit 6) set, the selected line follows the level bit (bit 7) both idle and during a burst. Level changes written mid-burst take effect at once.
- R8: Writing bit 31 high while idle starts a burst. Bit 31 reads back 1 until the burst ends and then clears itself. A total count of 0 completes with no serial clock edges.
- R9: A control write during a burst changes only the level bit. Polarity, phase, order, discard, index and manual mode keep their values.
- R10: At completion the done flag goes to 1 and stays there until a done_clr pulse. irq equals done ANDed with irq_en.
- R11: If a transmit byte is needed and the transmit queue is empty, the engine waits. It makes no clock edges, keeps sclk at the polarity level and stays busy. It resumes when data arrives.
- R12: After reset the control word reads 0, done and irq are 0, sclk is 0, all cs_n lines are high and no queue strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word readback, bit 31 = busy |
| total_count | input | 24 | Bytes in the burst, captured at start |
| tx_count | input | 24 | Bytes taken from the transmit queue, captured at start |
| done_clr | input | 1 | Write-one clear of the done flag |
| irq_en | input | 1 | Lets done reach irq |
| done | output | 1 | Transfer-complete flag |
| irq | output | 1 | Interrupt request |
| sclk_tick | input | 1 | Half-period serial clock enable |
| txq_empty | input | 1 | Transmit queue empty |
| txq_data | input | 8 | Transmit queue head byte |
| txq_pop | output | 1 | Transmit queue pop |
| rxq_push | output | 1 | Receive queue push |
| rxq_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select lines |

## Verification
The in-line properties check several things on every cycle. The control fields stay frozen during a burst. Completion sets done and clears busy. At most one chip-select line is low. The clock rests at the polarity level outside shifting. At completion, the numbers of pops and pushes match the two counts and the discard setting. Three things can only be shown by the bench's slave model, which samples and drives the wires per mode: correct bit placement, correct edge choice for each phase setting, and the zero fill after the transmit portion. The bench scenarios also cover the stall on an empty queue, the mid-burst manual level change and the zero-length burst.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int CTRL_W   = 32;
  localparam int CS_IDX_W = 2;
  localparam int CS_LINES = 1 << CS_IDX_W;

  // control word field positions
  localparam int PHA_BIT  = 0;
  localparam int POL_BIT  = 1;
  localparam int IDX_LO   = 4;
  localparam int MAN_BIT  = 6;
  localparam int LVL_BIT  = 7;
  localparam int DSC_BIT  = 8;
  localparam int ORD_BIT  = 12;
  localparam int GO_BIT   = 31;

  typedef struct packed {
    logic                lsb_first;
    logic                discard;
    logic                cs_level;
    logic                cs_manual;
    logic [CS_IDX_W-1:0] cs_idx;
    logic                cpol;
    logic                cpha;
  } spi_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SHIFT, ST_NEXT, ST_FIN
  } seq_state_t;

  function automatic spi_cfg_t cfg_from_word(input logic [CTRL_W-1:0] w);
    spi_cfg_t c;
    c.cpha      = w[PHA_BIT];
    c.cpol      = w[POL_BIT];
    c.cs_idx    = w[IDX_LO +: CS_IDX_W];
    c.cs_manual = w[MAN_BIT];
    c.cs_level  = w[LVL_BIT];
    c.discard   = w[DSC_BIT];
    c.lsb_first = w[ORD_BIT];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] word_from_cfg(input spi_cfg_t c, input logic go);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[PHA_BIT]             = c.cpha;
    w[POL_BIT]             = c.cpol;
    w[IDX_LO +: CS_IDX_W]  = c.cs_idx;
    w[MAN_BIT]             = c.cs_manual;
    w[LVL_BIT]             = c.cs_level;
    w[DSC_BIT]             = c.discard;
    w[ORD_BIT]             = c.lsb_first;
    w[GO_BIT]              = go;
    return w;
  endfunction
endpackage

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
  import spi_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              fin,
  input  logic              done_clr,
  input  logic              irq_en,
  output spi_cfg_t          cfg,
  output logic              busy,
  output logic              start,
  output logic              done,
  output logic              irq,
  output logic [CTRL_W-1:0] rd_data
);
  spi_cfg_t cfg_d;
  logic     busy_d, done_d;
  logic     ctrl_unused;

  assign ctrl_unused = ^{wr_data[30:13], wr_data[11:9], wr_data[3:2]};

  always_comb begin
    start  = wr_en & wr_data[GO_BIT] & ~busy;
    cfg_d  = cfg;
    busy_d = busy;
    done_d = done;
    if (wr_en) begin
      if (!busy) cfg_d = cfg_from_word(wr_data);
      else       cfg_d.cs_level = wr_data[LVL_BIT];   // R9: only level passes mid-burst
    end
    if (start)    busy_d = 1'b1;
    else if (fin) busy_d = 1'b0;
    if (fin)           done_d = 1'b1;
    else if (done_clr) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      cfg  <= cfg_d;
      busy <= busy_d;
      done <= done_d;
    end
  end

  assign rd_data = word_from_cfg(cfg, busy);
  assign irq     = done & irq_en;

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cfg.cpol) && $stable(cfg.cpha) && $stable(cfg.lsb_first)
                          && $stable(cfg.discard) && $stable(cfg.cs_idx) && $stable(cfg.cs_manual));
  a_r10_done_on_fin: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done);
  a_r8_go_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
  a_r10_clear_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_clr && !fin |=> !done);
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         run,
  input  logic         tick,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         byte_end,
  output logic [W-1:0] rx_byte
);
  localparam int            EW   = $clog2(2 * W);
  localparam logic [EW-1:0] LAST = EW'(2 * W - 1);

  logic [W-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic [EW-1:0] ec_q, ec_d;
  logic          ph_q, ph_d;
  logic          step, lead, samp, shft;

  always_comb begin
    step = run & tick;
    lead = ~ec_q[0];
    // R2: phase 0 samples on leading edges, phase 1 on trailing edges
    samp = step & (lead ^ cpha);
    shft = step & ~(lead ^ cpha) & (cpha ? (ec_q != '0) : (ec_q != LAST));
    tx_d = tx_q;
    rx_d = rx_q;
    ec_d = ec_q;
    ph_d = ph_q;
    if (load) begin
      tx_d = load_byte;
      ec_d = '0;
      ph_d = 1'b0;
    end else if (step) begin
      ec_d = ec_q + 1'b1;
      ph_d = ~ph_q;
      if (shft) tx_d = lsb_first ? {1'b0, tx_q[W-1:1]} : {tx_q[W-2:0], 1'b0};
      if (samp) rx_d = lsb_first ? {miso, rx_q[W-1:1]} : {rx_q[W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
      ec_q <= '0;
      ph_q <= 1'b0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
      ec_q <= ec_d;
      ph_q <= ph_d;
    end
  end

  assign sclk     = cpol ^ ph_q;
  assign mosi     = lsb_first ? tx_q[0] : tx_q[W-1];
  assign byte_end = step & (ec_q == LAST);
  assign rx_byte  = rx_q;

  a_r11_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> sclk == cpol);
  a_r2_end_on_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |-> sclk != cpol);
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [IW-1:0] idx,
  input  logic          manual,
  input  logic          level,
  input  logic          busy,
  output logic [N-1:0]  cs_n
);
  for (genvar i = 0; i < N; i++) begin : g_line
    // R6/R7: only the indexed line moves, by level or by burst activity
    assign cs_n[i] = (idx == IW'(i)) ? (manual ? level : ~busy) : 1'b1;
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_wr,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  output logic [CTRL_W-1:0]   ctrl_rdata,
  input  logic [CNT_W-1:0]    total_count,
  input  logic [CNT_W-1:0]    tx_count,
  input  logic                done_clr,
  input  logic                irq_en,
  output logic                done,
  output logic                irq,
  input  logic                sclk_tick,
  input  logic                txq_empty,
  input  logic [DATA_W-1:0]   txq_data,
  output logic                txq_pop,
  output logic                rxq_push,
  output logic [DATA_W-1:0]   rxq_data,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic [CS_LINES-1:0] cs_n
);
  spi_cfg_t          cfg;
  seq_state_t        st_q, st_d;
  logic [CNT_W-1:0]  tot_q, tot_d, txc_q, txc_d, idx_q, idx_d;
  logic              busy, start, fin, ld, need_tx, byte_end;
  logic [DATA_W-1:0] ld_byte;

  spi_ctrl_reg u_ctrl (
    .clk, .rst_n,
    .wr_en    (ctrl_wr),
    .wr_data  (ctrl_wdata),
    .fin,
    .done_clr,
    .irq_en,
    .cfg,
    .busy,
    .start,
    .done,
    .irq,
    .rd_data  (ctrl_rdata)
  );

  always_comb begin
    st_d     = st_q;
    tot_d    = tot_q;
    txc_d    = txc_q;
    idx_d    = idx_q;
    ld       = 1'b0;
    txq_pop  = 1'b0;
    rxq_push = 1'b0;
    fin      = 1'b0;
    need_tx  = idx_q < txc_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        tot_d = total_count;
        txc_d = tx_count;
        idx_d = '0;
        st_d  = (total_count == '0) ? ST_FIN : ST_LOAD;
      end
      ST_LOAD: if (!need_tx || !txq_empty) begin   // R11: wait for data
        ld      = 1'b1;
        txq_pop = need_tx;
        st_d    = ST_SHIFT;
      end
      ST_SHIFT: if (byte_end) st_d = ST_NEXT;
      ST_NEXT: begin
        rxq_push = ~cfg.discard;
        idx_d    = idx_q + 1'b1;
        st_d     = (idx_d == tot_q) ? ST_FIN : ST_LOAD;
      end
      ST_FIN: begin
        fin  = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tot_q <= '0;
      txc_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      tot_q <= tot_d;
      txc_q <= txc_d;
      idx_q <= idx_d;
    end
  end

  assign ld_byte = need_tx ? txq_data : '0;   // R4: zero fill past transmit count

  spi_bit_shifter #(.W(DATA_W)) u_shift (
    .clk, .rst_n,
    .load      (ld),
    .load_byte (ld_byte),
    .run       (st_q == ST_SHIFT),
    .tick      (sclk_tick),
    .cpol      (cfg.cpol),
    .cpha      (cfg.cpha),
    .lsb_first (cfg.lsb_first),
    .miso,
    .sclk,
    .mosi,
    .byte_end,
    .rx_byte   (rxq_data)
  );

  spi_cs_drive #(.N(CS_LINES), .IW(CS_IDX_W)) u_cs (
    .idx    (cfg.cs_idx),
    .manual (cfg.cs_manual),
    .level  (cfg.cs_level),
    .busy,
    .cs_n
  );

  // assertion support: per-burst strobe tallies
  logic [CNT_W-1:0] pop_tally, push_tally;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_tally  <= '0;
      push_tally <= '0;
    end else if (start) begin
      pop_tally  <= '0;
      push_tally <= '0;
    end else begin
      if (txq_pop)  pop_tally  <= pop_tally + 1'b1;
      if (rxq_push) push_tally <= push_tally + 1'b1;
    end
  end

  a_r4_pop_total: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> pop_tally == ((txc_q < tot_q) ? txc_q : tot_q));
  a_r5_push_total: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> push_tally == (cfg.discard ? '0 : tot_q));
  a_r6_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r4_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> !txq_empty);
endmodule

// File: tb/spi_burst_engine_test.sv
`timescale 1ns/1ps
module spi_burst_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic [23:0] total_count = '0;
  logic [23:0] tx_count = '0;
  logic        done_clr = 1'b0;
  logic        irq_en = 1'b0;
  logic        done, irq;
  logic        sclk_tick = 1'b0;
  logic        txq_empty;
  logic [7:0]  txq_data;
  logic        txq_pop, rxq_push;
  logic [7:0]  rxq_data;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [3:0]  cs_n;

  always #5 clk = ~clk;

  spi_burst_engine uut (
    .clk, .rst_n, .ctrl_wr, .ctrl_wdata, .ctrl_rdata, .total_count, .tx_count,
    .done_clr, .irq_en, .done, .irq, .sclk_tick, .txq_empty, .txq_data, .txq_pop,
    .rxq_push, .rxq_data, .sclk, .mosi, .miso, .cs_n
  );

  // queue models
  logic [7:0] tx_mem [0:255];
  logic [7:0] rx_mem [0:255];
  logic [7:0] tx_rd = '0, tx_avail = '0, rx_wr = '0;
  assign txq_empty = (tx_rd >= tx_avail);
  assign txq_data  = tx_mem[tx_rd];
  always @(posedge clk) if (txq_pop) tx_rd <= tx_rd + 1'b1;
  always @(posedge clk) if (rxq_push) begin rx_mem[rx_wr] <= rxq_data; rx_wr <= rx_wr + 1'b1; end

  // tick every third cycle
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    sclk_tick = (tdiv == 0);
  end

  int cur_cpol = 0, cur_cpha = 0, cur_lsb = 0, cur_seed = 0;
  int burst_id = 0;

  function automatic logic [7:0] tx_val(input int n, input int s);
    return 8'((n * 29 + s * 7 + 90) & 255);
  endfunction
  function automatic logic [7:0] sl_val(input int n, input int s);
    return 8'((n * 53 + s * 11 + 17) & 255);
  endfunction
  function automatic logic sl_bit(input int n, input int k);
    logic [7:0] v;
    v = sl_val(n, cur_seed);
    return cur_lsb != 0 ? v[k] : v[7-k];
  endfunction

  // slave model
  int seen_id = 0, sb = 0, sbyte = 0, edges = 0;
  logic prev_sclk = 1'b0;
  logic [7:0] gbyte;
  logic [7:0] got [0:63];
  always @(negedge clk) begin
    if (burst_id != seen_id) begin
      seen_id = burst_id; sb = 0; sbyte = 0; edges = 0;
      miso = sl_bit(0, 0);
    end else if (rst_n && sclk !== prev_sclk && ctrl_rdata[31]) begin
      edges++;
      if ((prev_sclk == cur_cpol[0]) != cur_cpha[0]) begin
        gbyte[cur_lsb != 0 ? sb : 7 - sb] = mosi;
        sb++;
        if (sb == 8) begin
          if (sbyte < 64) got[sbyte] = gbyte;
          sbyte++; sb = 0;
        end
      end else begin
        miso = sl_bit(sbyte, sb);
      end
    end
    prev_sclk = sclk;
  end

  int n_chk = 0, n_fail = 0;
  bit wd_hit = 0;
  logic [7:0] tx_base, rx_base;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(input int pha, input int pol, input int idx,
                                         input int man, input int lvl, input int dsc, input int lsb);
    logic [31:0] w;
    w = '0;
    w[0] = pha[0]; w[1] = pol[0]; w[5:4] = idx[1:0]; w[6] = man[0];
    w[7] = lvl[0]; w[8] = dsc[0]; w[12] = lsb[0];
    return w;
  endfunction

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic prep(input int pol, input int pha, input int lsb, input int seed,
                      input logic [31:0] word, input int tot, input int txc);
    cur_cpol = pol; cur_cpha = pha; cur_lsb = lsb; cur_seed = seed;
    tx_base = tx_rd; rx_base = rx_wr;
    for (int n = 0; n < txc; n++) tx_mem[8'(tx_base + n)] = tx_val(n, seed);
    tx_avail = 8'(tx_base + txc);
    wr_ctrl(word);
    total_count = 24'(tot); tx_count = 24'(txc);
    burst_id++;
    repeat (2) @(negedge clk);
    chk(ctrl_rdata == word, "R1", "control readback", ctrl_rdata, word);
    chk(sclk == pol[0], "R1", "idle clock level", sclk, pol);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 6000 && ctrl_rdata[31]; i++) @(negedge clk);
    chk(!ctrl_rdata[31], "R8", "start bit self-clears", ctrl_rdata[31], 0);
  endtask

  task automatic verify(input int tot, input int txc, input int dsc, input int ien, input int seed);
    int npop, exp_pop;
    npop = int'(8'(tx_rd - tx_base));
    exp_pop = (txc < tot) ? txc : tot;
    chk(npop == exp_pop, "R4", "pop count", npop, exp_pop);
    chk(int'(8'(rx_wr - rx_base)) == (dsc != 0 ? 0 : tot), "R5", "push count",
        int'(8'(rx_wr - rx_base)), dsc != 0 ? 0 : tot);
    chk(edges == 16 * tot, "R2", "clock edges", edges, 16 * tot);
    for (int n = 0; n < tot; n++) begin
      logic [7:0] e;
      e = (n < txc) ? tx_val(n, seed) : 8'h00;
      chk(got[n] == e, "R3", "byte seen by slave", got[n], e);
      if (dsc == 0)
        chk(rx_mem[8'(rx_base + n)] == sl_val(n, seed), "R5", "received byte",
            rx_mem[8'(rx_base + n)], sl_val(n, seed));
    end
    chk(done == 1'b1, "R10", "done set", done, 1);
    chk(irq == ien[0], "R10", "irq gating", irq, ien);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    chk(done == 1'b0, "R10", "done cleared", done, 0);
  endtask

  task automatic run_all();
    logic [31:0] w;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_rdata == 32'h0, "R12", "reset control", ctrl_rdata, 0);
    chk(cs_n == 4'hF && !done && !irq && !sclk && !txq_pop && !rxq_push, "R12",
        "reset outputs", {cs_n, done, irq, sclk}, 'h78);

    // sweep over modes and orders
    for (int m = 0; m < 4; m++) begin
      for (int lsb = 0; lsb < 2; lsb++) begin
        int pha, pol, txc, dsc, seed;
        pha = m & 1; pol = (m >> 1) & 1; txc = (m + lsb) % 4;
        dsc = (m == 2 && lsb == 1) ? 1 : 0; seed = m * 2 + lsb;
        irq_en = lsb[0];
        w = mkcfg(pha, pol, m, 0, 0, dsc, lsb);
        prep(pol, pha, lsb, seed, w, 3, txc);
        wr_ctrl(w | 32'h8000_0000);
        repeat (2) @(negedge clk);
        chk(ctrl_rdata[31], "R8", "busy readback", ctrl_rdata[31], 1);
        chk(cs_n == ~(4'b1 << m), "R6", "auto select low", cs_n, ~(4'b1 << m) & 4'hF);
        wait_idle();
        chk(cs_n == 4'hF, "R6", "released after burst", cs_n, 15);
        verify(3, txc, dsc, lsb, seed);
      end
    end

    // transmit count above total count
    w = mkcfg(1, 0, 1, 0, 0, 0, 0);
    prep(0, 1, 0, 9, w, 2, 3);
    wr_ctrl(w | 32'h8000_0000);
    wait_idle();
    verify(2, 3, 0, 1, 9);

    // zero-length burst (R8)
    w = mkcfg(0, 1, 0, 0, 0, 0, 0);
    prep(1, 0, 0, 3, w, 0, 0);
    wr_ctrl(w | 32'h8000_0000);
    repeat (4) @(negedge clk);
    chk(!ctrl_rdata[31], "R8", "zero burst finishes", ctrl_rdata[31], 0);
    verify(0, 0, 0, 1, 3);

    // manual chip select and mid-burst writes (R7, R9)
    w = mkcfg(0, 0, 2, 1, 0, 0, 0);
    prep(0, 0, 0, 5, w, 2, 2);
    chk(cs_n == 4'b1011, "R7", "manual low idle", cs_n, 11);
    wr_ctrl(mkcfg(0, 0, 2, 1, 1, 0, 0));
    chk(cs_n == 4'b1111, "R7", "manual high idle", cs_n, 15);
    wr_ctrl(w | 32'h8000_0000);
    repeat (3) @(negedge clk);
    chk(cs_n == 4'b1011, "R7", "manual low in burst", cs_n, 11);
    wr_ctrl(mkcfg(1, 1, 1, 0, 1, 1, 1) | 32'h8000_0000);
    chk(cs_n == 4'b1111, "R7", "level follows mid-burst", cs_n, 15);
    chk(ctrl_rdata[12:0] == 13'(mkcfg(0, 0, 2, 1, 1, 0, 0)), "R9", "other fields frozen",
        ctrl_rdata[12:0], mkcfg(0, 0, 2, 1, 1, 0, 0));
    wait_idle();
    verify(2, 2, 0, 1, 5);

    // empty transmit queue stall (R11)
    w = mkcfg(0, 1, 3, 0, 0, 0, 1);
    prep(1, 0, 1, 6, w, 3, 3);
    tx_avail = 8'(tx_base + 1);
    wr_ctrl(w | 32'h8000_0000);
    repeat (200) @(negedge clk);
    chk(edges == 16, "R11", "edges while stalled", edges, 16);
    chk(sclk == 1'b1, "R11", "clock rests at polarity", sclk, 1);
    chk(ctrl_rdata[31], "R11", "still busy", ctrl_rdata[31], 1);
    chk(8'(tx_rd - tx_base) == 8'd1, "R11", "no pop while empty", 8'(tx_rd - tx_base), 1);
    tx_avail = 8'(tx_base + 3);
    wait_idle();
    verify(3, 3, 0, 1, 6);
  endtask

  initial begin
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd_hit = 1; end
    join_any
    if (wd_hit) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule